// File: doc/BRIEF.md
# Per-Revision Protection Gatekeeper

This block holds two protection flags for each stored design revision: a read lock and a write lock. A command decoder in front of it issues single-cycle strobes that carry an operation code and a revision index. The block decides whether each strobe is granted or denied, and it updates the flags under fixed sequencing rules. Read and verify requests are refused while the read lock is set. Program and erase requests are refused while the write lock is set.

A read lock can be removed only by a granted erase of its revision. A write lock can be removed only by a two-step sequence: an unlock command, then an erase of the same revision as the very next command. A granted erase clears both flags of its revision. The OR of all read locks is exported as a single secure flag, which the test-access status capture uses.

The control is a two-state machine. In `ST_OPEN` every command is judged against the stored flags. An unlock command moves the machine to `ST_ARMED` and records the revision. In `ST_ARMED`, an erase of the recorded revision is granted whatever the write lock says, and the machine returns to `ST_OPEN`. Any other strobe also returns the machine to `ST_OPEN`, and that strobe is then judged as in `ST_OPEN`, so an unlock re-arms the machine. Cycles without a strobe leave the state as it is.

Top module: `rev_protect_ctrl`

## Requirements
- R1: After reset, every read lock and write lock is 0, `secure_o` is 0, and neither `grant_o` nor `deny_o` is asserted.
- R2: A read/verify strobe (op code 0) is granted when the read lock of the addressed revision is clear and denied when it is set. A set read lock has no effect on program (op 1) or erase (op 2).
- R3: A program strobe (op 1) is denied when the write lock of the addressed revision is set. An erase strobe (op 2) issued in `ST_OPEN` is also denied when that write lock is set.
- R4: A granted erase clears both locks of the addressed revision and leaves every other revision unchanged. No other command clears a read lock.
- R5: An unlock strobe (op 5) is always granted. When the next strobe is an erase of the same revision, that erase is granted even if the write lock is set, and both locks of the revision become 0.
- R6: After an unlock, any next strobe other than an erase of the recorded revision cancels the unlock. That strobe is judged against the stored locks. Strobe-free cycles do not cancel the unlock.
- R7: A denied strobe leaves every lock bit unchanged.
- R8: `secure_o` equals the OR of all read-lock bits.
- R9: Lock-read (op 3) and lock-write (op 4) are always granted and set the read or write lock of the addressed revision. Repeating them has no further effect.
- R10: Op codes 6 and 7 are reserved and are always denied.
- R11: Each strobe produces exactly one of `grant_o` or `deny_o`, high for one cycle, in the cycle after the strobe. With no strobe, both stay low. The lock outputs show the updated value in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Single-cycle command strobe |
| cmd_op_i | input | 3 | Operation code (0 read, 1 program, 2 erase, 3 lock-read, 4 lock-write, 5 unlock, 6-7 reserved) |
| cmd_rev_i | input | 2 | Target revision index |
| grant_o | output | 1 | Command accepted, one cycle after the strobe |
| deny_o | output | 1 | Command refused (error pulse), one cycle after the strobe |
| secure_o | output | 1 | OR of all read locks |
| rd_lock_o | output | 4 | Read lock per revision, bit i for revision i |
| wr_lock_o | output | 4 | Write lock per revision, bit i for revision i |

## Verification
The assertions check these rules on every cycle: a strobe is answered by exactly one response, a cycle without a strobe gives no response, a locked read or program is refused, a deny leaves every lock untouched, and a lock bit falls only after a clear aimed at its own revision. Only the bench's scenarios can show the ordering rules. These are that the unlock applies only to the very next strobe, that the erase must name the same revision, that idle gaps keep the machine armed, and that a cancelling strobe is still judged on its own merits. The bench checks them against an arithmetic model, first with directed sequences and then with a long pseudo-random sweep over every op code and revision.

// File: rtl/rev_prot_pkg.sv
package rev_prot_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_PROG    = 3'd1,
        OP_ERASE   = 3'd2,
        OP_LOCK_RD = 3'd3,
        OP_LOCK_WR = 3'd4,
        OP_UNLOCK  = 3'd5,
        OP_RSV6    = 3'd6,
        OP_RSV7    = 3'd7
    } prot_op_e;

    typedef enum logic {
        ST_OPEN  = 1'b0,
        ST_ARMED = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic set_rd;
        logic set_wr;
        logic clr_both;
    } bank_upd_t;

endpackage

// File: rtl/rev_prot_bank.sv
module rev_prot_bank
    import rev_prot_pkg::*;
#(
    parameter int NUM_REV = 4,
    parameter int REV_W   = (NUM_REV > 1) ? $clog2(NUM_REV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bank_upd_t          upd_i,
    input  logic [REV_W-1:0]   upd_rev_i,
    output logic [NUM_REV-1:0] rd_lock_o,
    output logic [NUM_REV-1:0] wr_lock_o
);

    for (genvar g = 0; g < NUM_REV; g++) begin : g_rev
        logic hit;
        assign hit = (upd_rev_i == REV_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_lock_o[g] <= 1'b0;
                wr_lock_o[g] <= 1'b0;
            end else if (hit) begin
                if (upd_i.clr_both) begin
                    rd_lock_o[g] <= 1'b0;
                    wr_lock_o[g] <= 1'b0;
                end else begin
                    if (upd_i.set_rd) rd_lock_o[g] <= 1'b1;
                    if (upd_i.set_wr) wr_lock_o[g] <= 1'b1;
                end
            end
        end

        AST_RD_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rd_lock_o[g]) |-> $past(upd_i.clr_both && upd_rev_i == REV_W'(g))); // R4
        AST_WR_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(wr_lock_o[g]) |-> $past(upd_i.clr_both && upd_rev_i == REV_W'(g))); // R5
    end

endmodule

// File: rtl/rev_any_or.sv
module rev_any_or #(
    parameter int NUM_REV = 4
) (
    input  logic [NUM_REV-1:0] bits_i,
    output logic               any_o
);

    logic [NUM_REV:0] chain;
    assign chain[0] = 1'b0;

    for (genvar g = 0; g < NUM_REV; g++) begin : g_or
        assign chain[g+1] = chain[g] | bits_i[g];
    end

    assign any_o = chain[NUM_REV];

endmodule

// File: rtl/rev_seq_fsm.sv
module rev_seq_fsm
    import rev_prot_pkg::*;
#(
    parameter int NUM_REV = 4,
    parameter int REV_W   = (NUM_REV > 1) ? $clog2(NUM_REV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    input  logic [2:0]       cmd_op_i,
    input  logic [REV_W-1:0] cmd_rev_i,
    input  logic             sel_rd_i,
    input  logic             sel_wr_i,
    output bank_upd_t        upd_o,
    output logic [REV_W-1:0] upd_rev_o,
    output logic             grant_o,
    output logic             deny_o
);

    seq_state_e       state_q, state_d;
    logic [REV_W-1:0] arm_rev_q, arm_rev_d;
    logic             grant_d;
    prot_op_e         op;

    assign op        = prot_op_e'(cmd_op_i);
    assign upd_rev_o = cmd_rev_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OPEN;
            arm_rev_q <= '0;
            grant_o   <= 1'b0;
            deny_o    <= 1'b0;
        end else begin
            state_q   <= state_d;
            arm_rev_q <= arm_rev_d;
            grant_o   <= cmd_valid_i && grant_d;
            deny_o    <= cmd_valid_i && !grant_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        arm_rev_d = arm_rev_q;
        grant_d   = 1'b0;
        upd_o     = '0;
        if (cmd_valid_i) begin
            if (state_q == ST_ARMED && op == OP_ERASE && cmd_rev_i == arm_rev_q) begin
                grant_d        = 1'b1;
                upd_o.clr_both = 1'b1;
                state_d        = ST_OPEN;
            end else begin
                state_d = ST_OPEN;
                unique case (op)
                    OP_READ:  grant_d = !sel_rd_i;
                    OP_PROG:  grant_d = !sel_wr_i;
                    OP_ERASE: begin
                        grant_d        = !sel_wr_i;
                        upd_o.clr_both = !sel_wr_i;
                    end
                    OP_LOCK_RD: begin
                        grant_d      = 1'b1;
                        upd_o.set_rd = 1'b1;
                    end
                    OP_LOCK_WR: begin
                        grant_d      = 1'b1;
                        upd_o.set_wr = 1'b1;
                    end
                    OP_UNLOCK: begin
                        grant_d   = 1'b1;
                        state_d   = ST_ARMED;
                        arm_rev_d = cmd_rev_i;
                    end
                    default: grant_d = 1'b0;
                endcase
            end
        end
    end

    AST_READ_LOCK_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i && op == OP_READ && sel_rd_i |=> deny_o && !grant_o); // R2
    AST_PROG_LOCK_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i && op == OP_PROG && sel_wr_i |=> deny_o && !grant_o); // R3
    AST_RSV_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i && cmd_op_i[2:1] == 2'b11 |=> deny_o); // R10
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i |=> $onehot({grant_o, deny_o})); // R11
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_i |=> !grant_o && !deny_o); // R11
    AST_IDLE_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_i && state_q == ST_ARMED |=> state_q == ST_ARMED); // R6

endmodule

// File: rtl/rev_protect_ctrl.sv
module rev_protect_ctrl
    import rev_prot_pkg::*;
#(
    parameter int NUM_REV = 4,
    parameter int REV_W   = (NUM_REV > 1) ? $clog2(NUM_REV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid_i,
    input  logic [2:0]         cmd_op_i,
    input  logic [REV_W-1:0]   cmd_rev_i,
    output logic               grant_o,
    output logic               deny_o,
    output logic               secure_o,
    output logic [NUM_REV-1:0] rd_lock_o,
    output logic [NUM_REV-1:0] wr_lock_o
);

    bank_upd_t        upd;
    logic [REV_W-1:0] upd_rev;
    logic             sel_rd, sel_wr;

    assign sel_rd = rd_lock_o[cmd_rev_i];
    assign sel_wr = wr_lock_o[cmd_rev_i];

    rev_seq_fsm #(.NUM_REV(NUM_REV), .REV_W(REV_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid_i(cmd_valid_i),
        .cmd_op_i   (cmd_op_i),
        .cmd_rev_i  (cmd_rev_i),
        .sel_rd_i   (sel_rd),
        .sel_wr_i   (sel_wr),
        .upd_o      (upd),
        .upd_rev_o  (upd_rev),
        .grant_o    (grant_o),
        .deny_o     (deny_o)
    );

    rev_prot_bank #(.NUM_REV(NUM_REV), .REV_W(REV_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (upd),
        .upd_rev_i(upd_rev),
        .rd_lock_o(rd_lock_o),
        .wr_lock_o(wr_lock_o)
    );

    rev_any_or #(.NUM_REV(NUM_REV)) u_any (
        .bits_i(rd_lock_o),
        .any_o (secure_o)
    );

    AST_DENY_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        deny_o |-> $stable(rd_lock_o) && $stable(wr_lock_o)); // R7
    AST_SECURE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(secure_o) |-> $past(cmd_valid_i && cmd_op_i == 3'd3)); // R8

endmodule

// File: tb/rev_protect_ctrl_tb_top.sv
module rev_protect_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [1:0] cmd_rev = '0;
    logic       grant, deny, secure;
    logic [3:0] rd_lock, wr_lock;

    int total = 0;
    int bad = 0;

    logic [3:0] m_rd = '0, m_wr = '0;
    logic       m_armed = 1'b0;
    logic [1:0] m_arm_rev = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    rev_protect_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_rev_i(cmd_rev), .grant_o(grant), .deny_o(deny), .secure_o(secure),
        .rd_lock_o(rd_lock), .wr_lock_o(wr_lock)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drives one cycle (strobe or idle) and checks the cycle after it.
    task automatic step(input bit v, input logic [2:0] op, input logic [1:0] rev, input string tag);
        bit eg;
        eg = 1'b0;
        if (v) begin
            if (m_armed && op == 3'd2 && rev == m_arm_rev) begin
                eg = 1'b1; m_rd[rev] = 1'b0; m_wr[rev] = 1'b0; m_armed = 1'b0;
            end else begin
                m_armed = 1'b0;
                case (op)
                    3'd0: eg = !m_rd[rev];
                    3'd1: eg = !m_wr[rev];
                    3'd2: begin eg = !m_wr[rev]; if (eg) begin m_rd[rev] = 1'b0; m_wr[rev] = 1'b0; end end
                    3'd3: begin eg = 1'b1; m_rd[rev] = 1'b1; end
                    3'd4: begin eg = 1'b1; m_wr[rev] = 1'b1; end
                    3'd5: begin eg = 1'b1; m_armed = 1'b1; m_arm_rev = rev; end
                    default: eg = 1'b0;
                endcase
            end
        end
        cmd_valid = v; cmd_op = op; cmd_rev = rev;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({grant, deny} == {v && eg, v && !eg}, {tag, " R11 response"}, {grant, deny}, {v && eg, v && !eg});
        chk(rd_lock == m_rd, {tag, " R4 read locks"}, rd_lock, m_rd);
        chk(wr_lock == m_wr, {tag, " R7 write locks"}, wr_lock, m_wr);
        chk(secure == (|m_rd), {tag, " R8 secure"}, secure, |m_rd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_lock == 4'h0 && wr_lock == 4'h0, "R1 locks after reset", {rd_lock, wr_lock}, 0);
        chk(!secure && !grant && !deny, "R1 outputs after reset", {secure, grant, deny}, 0);

        step(1, 3'd3, 2'd1, "R9 lock-read rev1");
        step(1, 3'd3, 2'd1, "R9 lock-read repeat");
        step(1, 3'd0, 2'd1, "R2 read locked rev1");
        step(1, 3'd0, 2'd0, "R2 read open rev0");
        step(1, 3'd1, 2'd1, "R2 program ignores read lock");
        step(1, 3'd4, 2'd2, "R9 lock-write rev2");
        step(1, 3'd1, 2'd2, "R3 program locked rev2");
        step(1, 3'd2, 2'd2, "R3 erase locked rev2");
        step(1, 3'd5, 2'd2, "R5 unlock rev2");
        step(1, 3'd0, 2'd0, "R6 other command");
        step(1, 3'd2, 2'd2, "R6 erase after cancel");
        step(1, 3'd3, 2'd2, "R9 lock-read rev2");
        step(1, 3'd5, 2'd2, "R5 unlock rev2 again");
        step(0, 3'd0, 2'd0, "R6 idle gap");
        step(0, 3'd0, 2'd0, "R6 idle gap");
        step(1, 3'd2, 2'd2, "R5 erase after unlock");
        step(1, 3'd4, 2'd3, "R9 lock-write rev3");
        step(1, 3'd5, 2'd3, "R6 unlock rev3");
        step(1, 3'd2, 2'd0, "R6 erase other rev");
        step(1, 3'd2, 2'd3, "R6 erase rev3 after cancel");
        step(1, 3'd2, 2'd1, "R4 erase clears read lock rev1");
        step(1, 3'd6, 2'd0, "R10 reserved op 6");
        step(1, 3'd7, 2'd3, "R10 reserved op 7");

        for (int n = 0; n < 6000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[7], lfsr[3:1], lfsr[5:4], "R2 R3 R5 R6 sweep");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule